// File: doc/BRIEF.md
# Subchannel Engine Write Router

This block sits between a command decoder and a set of engine register ports. Each incoming request carries a method number, a 3-bit subchannel and a 32-bit value. An eight-entry table records which engine class is attached to each subchannel. A request with method zero loads that table. A request with a method at or above 0x100 is steered to the engine port that matches the class bound to its subchannel.

Methods 1 to 0xFF are reserved. They are discarded and reported. Four single-cycle error pulses report the bad cases:

- a second bind to a subchannel that is already bound,
- a write to a subchannel that has no binding,
- a reserved method,
- a bound class that no attached engine handles.

The input uses a valid/ready handshake. A forwarded request reaches its engine port in the same cycle it is offered. It is held there until that port is ready.

Top module: `subch_dispatch`

## Requirements
- R1: After reset all eight subchannels are unbound. A method of 0x100 or above sent to any of them then raises `err_unbound`.
- R2: A method-0 request to an unbound subchannel stores its 32-bit value as that subchannel's engine class. It is accepted at once (`req_ready`=1) and strobes no engine port.
- R3: The bound class picks the port. Class 0x902D selects port index 0 (2D), 0xB197 selects index 1 (3D) and 0xB1C0 selects index 2 (compute). The forwarded method and value equal the request's, and exactly one `eng_valid` bit is high.
- R4: Methods 1 to 0xFF reach no engine. They are accepted at once and raise `err_reserved`. Method 0x100 is the lowest method that is forwarded.
- R5: A method-0 request to a bound subchannel raises `err_rebind` and leaves the existing binding unchanged. Later writes still go to the old port.
- R6: A method of 0x100 or above to an unbound subchannel is not forwarded and raises `err_unbound`.
- R7: A bound class other than the three handled ones (for example 0xA140 or 0xB0B5) forwards nothing on a write and raises `err_bad_engine`.
- R8: While the selected port's `eng_ready` is low, `req_ready` is low and no flag fires. The request is taken on the first cycle that port is ready.
- R9: Each error flag is a one-cycle pulse in the cycle after the request is accepted, and at most one flag is high at a time.
- R10: The eight table entries are independent. A bind on one subchannel never alters the routing of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_method | input | 13 | Method number |
| req_sub | input | 3 | Subchannel |
| req_value | input | 32 | Write data or engine class |
| eng_valid | output | 3 | Per-engine write strobe (0 = 2D, 1 = 3D, 2 = compute) |
| eng_ready | input | 3 | Per-engine ready |
| eng_method | output | 3x13 | Method to each engine |
| eng_value | output | 3x32 | Value to each engine |
| err_rebind | output | 1 | Bind to an already bound subchannel |
| err_unbound | output | 1 | Write to an unbound subchannel |
| err_reserved | output | 1 | Reserved method dropped |
| err_bad_engine | output | 1 | Bound class has no engine port |

## Verification
A corrupt table entry does not show until the next write to that subchannel. It then appears as a strobe on the wrong port, a missing strobe or a wrong error pulse. Random traffic therefore returns to every subchannel many times after it is bound. Routing faults are visible in the same cycle as the request. Classification faults appear one cycle later on the flag outputs. A stall fault shows as `req_ready` disagreeing with the selected port's ready.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int NUM_ENG = 3;
  localparam logic [31:0] CLS_2D  = 32'h0000_902D;
  localparam logic [31:0] CLS_3D  = 32'h0000_B197;
  localparam logic [31:0] CLS_CMP = 32'h0000_B1C0;
  localparam logic [1:0]  PORT_NONE = 2'd3;

  typedef enum logic [2:0] {
    ACT_BIND    = 3'd0,
    ACT_REBIND  = 3'd1,
    ACT_RESVD   = 3'd2,
    ACT_UNBOUND = 3'd3,
    ACT_BADENG  = 3'd4,
    ACT_FWD     = 3'd5
  } sd_act_e;

  function automatic logic [1:0] sd_port_of(input logic [31:0] cls);
    case (cls)
      CLS_2D:  return 2'd0;
      CLS_3D:  return 2'd1;
      CLS_CMP: return 2'd2;
      default: return PORT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sd_bind_table.sv
module sd_bind_table #(
  parameter int SUB_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SUB_W-1:0]  wr_sub,
  input  logic [DATA_W-1:0] wr_cls,
  input  logic [SUB_W-1:0]  rd_sub,
  output logic              rd_bound,
  output logic [DATA_W-1:0] rd_cls
);
  localparam int ENTRIES = 1 << SUB_W;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][DATA_W-1:0] ent_cls;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[e] <= 1'b0;
        ent_cls[e]   <= '0;
      end else if (wr_en && (wr_sub == SUB_W'(e))) begin
        ent_valid[e] <= 1'b1;
        ent_cls[e]   <= wr_cls;
      end
    end
  end

  assign rd_bound = ent_valid[rd_sub];
  assign rd_cls   = ent_cls[rd_sub];
endmodule

// File: rtl/sd_classify.sv
module sd_classify
  import sd_pkg::*;
#(
  parameter int METHOD_W  = 13,
  parameter int DATA_W    = 32,
  parameter int RSV_LIMIT = 256
) (
  input  logic [METHOD_W-1:0] method,
  input  logic                bound,
  input  logic [DATA_W-1:0]   cls,
  output sd_act_e             act,
  output logic [1:0]          port
);
  always_comb begin
    port = sd_port_of(32'(cls));
    if (method == '0)
      act = bound ? ACT_REBIND : ACT_BIND;
    else if (method < METHOD_W'(RSV_LIMIT))
      act = ACT_RESVD;
    else if (!bound)
      act = ACT_UNBOUND;
    else if (port == PORT_NONE)
      act = ACT_BADENG;
    else
      act = ACT_FWD;
  end
endmodule

// File: rtl/subch_dispatch.sv
module subch_dispatch
  import sd_pkg::*;
#(
  parameter int METHOD_W  = 13,
  parameter int SUB_W     = 3,
  parameter int DATA_W    = 32,
  parameter int RSV_LIMIT = 256
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [METHOD_W-1:0]                req_method,
  input  logic [SUB_W-1:0]                   req_sub,
  input  logic [DATA_W-1:0]                  req_value,
  output logic [NUM_ENG-1:0]                 eng_valid,
  input  logic [NUM_ENG-1:0]                 eng_ready,
  output logic [NUM_ENG-1:0][METHOD_W-1:0]   eng_method,
  output logic [NUM_ENG-1:0][DATA_W-1:0]     eng_value,
  output logic                               err_rebind,
  output logic                               err_unbound,
  output logic                               err_reserved,
  output logic                               err_bad_engine
);
  logic              sub_bound;
  logic [DATA_W-1:0] sub_cls;
  sd_act_e           act;
  logic [1:0]        sel_port;
  logic              sel_ready;
  logic              accept;
  logic              bind_wr;
  logic              fwd_req;

  sd_bind_table #(.SUB_W(SUB_W), .DATA_W(DATA_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bind_wr),
    .wr_sub   (req_sub),
    .wr_cls   (req_value),
    .rd_sub   (req_sub),
    .rd_bound (sub_bound),
    .rd_cls   (sub_cls)
  );

  sd_classify #(.METHOD_W(METHOD_W), .DATA_W(DATA_W), .RSV_LIMIT(RSV_LIMIT)) u_class (
    .method (req_method),
    .bound  (sub_bound),
    .cls    (sub_cls),
    .act    (act),
    .port   (sel_port)
  );

  always_comb begin
    sel_ready = 1'b0;
    for (int k = 0; k < NUM_ENG; k++)
      if (sel_port == 2'(k)) sel_ready = eng_ready[k];
  end

  assign fwd_req   = req_valid && (act == ACT_FWD);
  assign req_ready = (act == ACT_FWD) ? sel_ready : 1'b1;
  assign accept    = req_valid && req_ready;
  assign bind_wr   = accept && (act == ACT_BIND);

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_port
    assign eng_valid[k]  = fwd_req && (sel_port == 2'(k));
    assign eng_method[k] = req_method;
    assign eng_value[k]  = req_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_rebind     <= 1'b0;
      err_unbound    <= 1'b0;
      err_reserved   <= 1'b0;
      err_bad_engine <= 1'b0;
    end else begin
      err_rebind     <= accept && (act == ACT_REBIND);
      err_unbound    <= accept && (act == ACT_UNBOUND);
      err_reserved   <= accept && (act == ACT_RESVD);
      err_bad_engine <= accept && (act == ACT_BADENG);
    end
  end
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int METHOD_W  = 13,
  parameter int NUM_ENG   = 3,
  parameter int RSV_LIMIT = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [METHOD_W-1:0] req_method,
  input logic [NUM_ENG-1:0]  eng_valid,
  input logic [NUM_ENG-1:0]  eng_ready,
  input logic                sub_bound,
  input logic                err_rebind,
  input logic                err_unbound,
  input logic                err_reserved,
  input logic                err_bad_engine
);
  logic is_low;
  assign is_low = req_method < METHOD_W'(RSV_LIMIT);

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid)) else $error("one port"); // R3
  AST_LOW_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_low) |-> (eng_valid == '0)) else $error("low fwd"); // R4
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_low && req_method != '0) |=> err_reserved) else $error("rsv flag"); // R4
  AST_UNBOUND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_low && !sub_bound) |=> err_unbound) else $error("unbound"); // R6
  AST_REBIND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_method == '0 && sub_bound) |=> err_rebind) else $error("rebind"); // R5
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid != '0) |-> (req_ready == ((eng_valid & eng_ready) != '0))) else $error("stall"); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !(err_rebind || err_unbound || err_reserved || err_bad_engine))
    else $error("stall flag"); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_rebind, err_unbound, err_reserved, err_bad_engine})) else $error("excl"); // R9
endmodule

bind subch_dispatch sd_checker #(.METHOD_W(METHOD_W), .NUM_ENG(sd_pkg::NUM_ENG), .RSV_LIMIT(RSV_LIMIT)) u_sd_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_method     (req_method),
  .eng_valid      (eng_valid),
  .eng_ready      (eng_ready),
  .sub_bound      (sub_bound),
  .err_rebind     (err_rebind),
  .err_unbound    (err_unbound),
  .err_reserved   (err_reserved),
  .err_bad_engine (err_bad_engine)
);

// File: tb/test_subch_dispatch.sv
`timescale 1ns/1ps
module test_subch_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [12:0] req_method = '0;
  logic [2:0]  req_sub = '0;
  logic [31:0] req_value = '0;
  logic [2:0]  eng_valid;
  logic [2:0]  eng_ready = 3'b111;
  logic [2:0][12:0] eng_method;
  logic [2:0][31:0] eng_value;
  logic err_rebind, err_unbound, err_reserved, err_bad_engine;

  int n_chk = 0;
  int n_bad = 0;
  logic        mdl_v [8];
  logic [31:0] mdl_c [8];

  always #10 clk = ~clk;

  subch_dispatch i_subch_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_method(req_method), .req_sub(req_sub), .req_value(req_value),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_method(eng_method),
    .eng_value(eng_value), .err_rebind(err_rebind), .err_unbound(err_unbound),
    .err_reserved(err_reserved), .err_bad_engine(err_bad_engine)
  );

  function automatic int port_for(input logic [31:0] c);
    if (c == 32'h902D) return 0;
    if (c == 32'hB197) return 1;
    if (c == 32'hB1C0) return 2;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kinds: 0 bind, 1 rebind, 2 reserved, 3 unbound, 4 bad engine, 5 forward
  task automatic apply(input logic [2:0] s, input logic [12:0] m, input logic [31:0] v,
                       input logic [2:0] rdy, input string req);
    int kind, p;
    logic [2:0] ev;
    logic er;
    logic [3:0] ef;
    @(negedge clk);
    req_valid = 1'b1; req_sub = s; req_method = m; req_value = v; eng_ready = rdy;
    #1;
    p = port_for(mdl_c[s]);
    if (m == 0) kind = mdl_v[s] ? 1 : 0;
    else if (m < 13'h100) kind = 2;
    else if (!mdl_v[s]) kind = 3;
    else if (p == 3) kind = 4;
    else kind = 5;
    ev = (kind == 5) ? (3'b001 << p) : 3'b000;
    er = (kind == 5) ? rdy[p] : 1'b1;
    check(eng_valid == ev, {req, " eng_valid"}, 64'(eng_valid), 64'(ev));
    check(req_ready == er, {req, " R8 req_ready"}, 64'(req_ready), 64'(er));
    if (kind == 5) begin
      check(eng_method[p] == m && eng_value[p] == v, {req, " R3 passthru"},
            {eng_method[p], eng_value[p]}, {m, v});
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    ef = 4'b0;
    if (er) ef[3 - ((kind == 1) ? 0 : (kind == 3) ? 1 : (kind == 2) ? 2 : 3)] =
            (kind >= 1 && kind <= 4);
    check({err_rebind, err_unbound, err_reserved, err_bad_engine} == ef, {req, " R9 flags"},
          64'({err_rebind, err_unbound, err_reserved, err_bad_engine}), 64'(ef));
    if (er && kind == 0) begin
      mdl_v[s] = 1'b1; mdl_c[s] = v;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] cls_set [6];
    void'($urandom(32'h5D1));
    cls_set[0] = 32'h902D; cls_set[1] = 32'hB197; cls_set[2] = 32'hB1C0;
    cls_set[3] = 32'hA140; cls_set[4] = 32'hB0B5; cls_set[5] = 32'h1234;
    for (int i = 0; i < 8; i++) begin mdl_v[i] = 1'b0; mdl_c[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check({err_rebind, err_unbound, err_reserved, err_bad_engine, eng_valid} == '0,
          "R1 reset outputs", 64'({err_rebind, err_unbound, err_reserved, err_bad_engine, eng_valid}), 64'(0));
    for (int i = 0; i < 8; i++) apply(3'(i), 13'h100, 32'h11, 3'b111, "R1 unbound after reset");
    apply(3'd0, 13'h200, 32'h22, 3'b111, "R6 unbound");
    apply(3'd0, 13'h0, 32'h902D, 3'b111, "R2 bind 2d");
    apply(3'd1, 13'h0, 32'hB197, 3'b111, "R2 bind 3d");
    apply(3'd2, 13'h0, 32'hB1C0, 3'b111, "R2 bind cmp");
    apply(3'd3, 13'h0, 32'hA140, 3'b111, "R2 bind other");
    apply(3'd4, 13'h0, 32'hB0B5, 3'b111, "R2 bind other2");
    apply(3'd0, 13'h100, 32'hAAAA5555, 3'b111, "R3 port0 edge 0x100");
    apply(3'd1, 13'h1FFF, 32'h12345678, 3'b111, "R3 port1");
    apply(3'd2, 13'h345, 32'hDEADBEEF, 3'b111, "R3 port2");
    apply(3'd3, 13'h300, 32'h1, 3'b111, "R7 class A140");
    apply(3'd4, 13'h300, 32'h2, 3'b111, "R7 class B0B5");
    apply(3'd0, 13'h001, 32'h3, 3'b111, "R4 reserved 1");
    apply(3'd1, 13'h0FF, 32'h4, 3'b111, "R4 reserved FF");
    apply(3'd0, 13'h0, 32'hB197, 3'b111, "R5 rebind");
    apply(3'd0, 13'h400, 32'h5, 3'b111, "R5 old binding kept");
    apply(3'd5, 13'h400, 32'h6, 3'b111, "R10 other subchannel unbound");
    apply(3'd1, 13'h500, 32'h7, 3'b101, "R8 stall port1");
    apply(3'd1, 13'h500, 32'h7, 3'b101, "R8 still stalled");
    apply(3'd1, 13'h500, 32'h7, 3'b010, "R8 release");
    for (int i = 0; i < 500; i++) begin
      logic [12:0] m;
      logic [31:0] v;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 2) m = 13'h0;
      else if (sel < 3) m = 13'($urandom_range(1, 255));
      else m = 13'($urandom_range(256, 8191));
      v = (m == 0) ? cls_set[$urandom_range(0, 5)] : $urandom;
      apply(3'($urandom_range(0, 7)), m, v, 3'($urandom_range(0, 7)), "R10 random");
    end
    summary();
    $finish;
  end
endmodule